// File: doc/BRIEF.md
# Device Sleep Timing Controller

This block drives the device-sleep output of one storage link port. It holds a 32-bit control word that carries an idle timeout with a zero-based multiplier, a minimum hold time for the sleep signal, an exit timeout, a platform-support flag and an aggressive-entry flag. A free-running 1 ms tick pulse paces all three timers. The port supplies a port-idle level, a one-cycle software sleep request and a wake request.

The sleep signal can assert in two ways. Software can ask for it, or, when aggressive entry is on, the port can stay idle for long enough. Once the signal is asserted it is held for at least the minimum hold time. A wake request that arrives earlier is remembered and served on the tick that completes the hold. After the signal drops, a ready flag stays low until the exit timeout has run, and then tells the link that it may begin its wake-up signalling. Sleep requests are ignored while that exit window is running.

Top module: `dsl_top`

## Requirements
- R1: After reset the control word reads 0x1E022852: multiplier [28:25]=15, idle timeout [24:15]=4, minimum hold [14:10]=10, exit timeout [9:2]=20, platform-support bit 1 = 1, aggressive bit 0 = 0. A write with `cfg_we` high replaces the word on the next clock edge.
- R2: Bits [31:29] of the control word always read as zero, whatever value is written to them.
- R3: When bit 0 = 1 and bit 1 = 1, the sleep output rises on the clock edge of the tick on which the count of consecutive idle ticks reaches idle timeout × (multiplier + 1). Dropping `port_idle` for any cycle sets that count back to zero.
- R4: When bit 0 = 0, idle time never asserts sleep. A `sw_sleep_req` pulse seen while awake asserts sleep on the next clock edge.
- R5: While bit 1 = 0, sleep is never asserted. Clearing bit 1 while asleep deasserts sleep on the clock edge after the write takes effect.
- R6: A wake request seen before the minimum hold has passed is kept pending. Sleep then drops on the edge of the tick that brings the number of ticks since assertion up to the minimum hold.
- R7: A change of bit 0 from 1 to 0 while sleep is asserted drops sleep on the next clock edge, even if the minimum hold has not yet passed.
- R8: The ready flag is low while asleep and after deassertion. It rises on the edge of the tick that brings the number of ticks since deassertion up to the exit timeout. Sleep requests are ignored until it rises.
- R9: An idle timeout, minimum hold or exit timeout field of zero behaves as one tick.
- R10: During and just after reset, sleep is low and ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| port_idle | input | 1 | Port has no traffic |
| sw_sleep_req | input | 1 | Software request to enter sleep |
| wake_req | input | 1 | Request to leave sleep |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Current control word |
| sleep_o | output | 1 | Device sleep signal |
| link_ready_o | output | 1 | Exit timeout elapsed; link wake-up may start |

## Verification
The bench goes after the off-by-one edges of each timer: one tick short of the idle limit, of the hold and of the exit window, where a design that compares with the wrong operator or reacts one edge late would toggle a cycle away from the model. It drops port idle partway through a countdown, which catches a counter that only pauses. It sends a wake request early, which catches a design that either drops sleep at once or loses the request. It clears the aggressive and platform bits while asleep, which catches a forced exit that waits for the hold. It also sets zero-valued fields, where a design without the one-tick floor would assert on the cycle right after the write or never leave its state.

// File: rtl/dsl_pkg.sv
package dsl_pkg;
    localparam int WORD_W   = 32;
    localparam int MULT_W   = 4;
    localparam int MULT_LSB = 25;
    localparam int IDLE_W   = 10;
    localparam int IDLE_LSB = 15;
    localparam int HOLD_W   = 5;
    localparam int HOLD_LSB = 10;
    localparam int EXIT_W   = 8;
    localparam int EXIT_LSB = 2;
    localparam int PLAT_BIT = 1;
    localparam int AGGR_BIT = 0;
    localparam int RSVD_LSB = MULT_LSB + MULT_W;
    localparam int CNT_W    = IDLE_W + MULT_W + 1;

    localparam logic [WORD_W-1:0] WRITE_MASK = {WORD_W{1'b1}} >> (WORD_W - RSVD_LSB);
    localparam logic [WORD_W-1:0] CFG_RESET =
          (WORD_W'(15) << MULT_LSB) | (WORD_W'(4) << IDLE_LSB)
        | (WORD_W'(10) << HOLD_LSB) | (WORD_W'(20) << EXIT_LSB)
        | (WORD_W'(1) << PLAT_BIT);

    typedef enum logic [1:0] {PH_AWAKE, PH_ASLEEP, PH_EXIT} phase_e;

    typedef struct packed {
        logic [MULT_W-1:0] mult;
        logic [IDLE_W-1:0] idle;
        logic [HOLD_W-1:0] hold;
        logic [EXIT_W-1:0] exit_wait;
        logic              plat_ok;
        logic              aggr;
    } cfg_t;

    typedef struct packed {
        logic [CNT_W-1:0] idle_lim;
        logic [CNT_W-1:0] hold_lim;
        logic [CNT_W-1:0] exit_lim;
    } lim_t;
endpackage

// File: rtl/dsl_cfg_reg.sv
module dsl_cfg_reg
    import dsl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output cfg_t              cfg,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (we) begin
            word_d = wdata & WRITE_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= CFG_RESET;
        end else begin
            word_q <= word_d;
        end
    end

    assign rdata         = word_q;
    assign cfg.mult      = word_q[MULT_LSB +: MULT_W];
    assign cfg.idle      = word_q[IDLE_LSB +: IDLE_W];
    assign cfg.hold      = word_q[HOLD_LSB +: HOLD_W];
    assign cfg.exit_wait = word_q[EXIT_LSB +: EXIT_W];
    assign cfg.plat_ok   = word_q[PLAT_BIT];
    assign cfg.aggr      = word_q[AGGR_BIT];
endmodule

// File: rtl/dsl_limits.sv
module dsl_limits
    import dsl_pkg::*;
(
    input  cfg_t cfg,
    output lim_t lim
);
    logic [IDLE_W-1:0] idle_eff;
    logic [HOLD_W-1:0] hold_eff;
    logic [EXIT_W-1:0] exit_eff;
    logic [MULT_W:0]   mult_eff;

    always_comb begin
        idle_eff = (cfg.idle == '0) ? IDLE_W'(1) : cfg.idle;
        hold_eff = (cfg.hold == '0) ? HOLD_W'(1) : cfg.hold;
        exit_eff = (cfg.exit_wait == '0) ? EXIT_W'(1) : cfg.exit_wait;
        mult_eff = {1'b0, cfg.mult} + (MULT_W+1)'(1);
        lim.idle_lim = CNT_W'(idle_eff) * CNT_W'(mult_eff);
        lim.hold_lim = CNT_W'(hold_eff);
        lim.exit_lim = CNT_W'(exit_eff);
    end
endmodule

// File: rtl/dsl_seq.sv
module dsl_seq
    import dsl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic port_idle,
    input  logic sw_req,
    input  logic wake_req,
    input  cfg_t cfg,
    input  lim_t lim,
    output logic sleep,
    output logic ready
);
    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic             pend;
        logic             aggr_prev;
        logic             sleep;
        logic             ready;
    } seq_t;

    localparam seq_t SEQ_RESET = '{phase: PH_AWAKE, cnt: '0, pend: 1'b0,
                                   aggr_prev: 1'b0, sleep: 1'b0, ready: 1'b1};

    seq_t s_d, s_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             wake_any;
    logic             forced;

    always_comb begin
        s_d           = s_q;
        s_d.aggr_prev = cfg.aggr;
        cnt_inc       = (&s_q.cnt) ? s_q.cnt : s_q.cnt + CNT_W'(tick);
        wake_any      = s_q.pend | wake_req;
        forced        = !cfg.plat_ok || (s_q.aggr_prev && !cfg.aggr);
        unique case (s_q.phase)
            PH_AWAKE: begin
                s_d.cnt = port_idle ? cnt_inc : '0;
                if (cfg.plat_ok &&
                    (sw_req || (cfg.aggr && port_idle && cnt_inc >= lim.idle_lim))) begin
                    s_d.phase = PH_ASLEEP;
                    s_d.cnt   = '0;
                    s_d.pend  = 1'b0;
                    s_d.sleep = 1'b1;
                    s_d.ready = 1'b0;
                end
            end
            PH_ASLEEP: begin
                s_d.cnt  = cnt_inc;
                s_d.pend = wake_any;
                if (forced || (wake_any && cnt_inc >= lim.hold_lim)) begin
                    s_d.phase = PH_EXIT;
                    s_d.cnt   = '0;
                    s_d.pend  = 1'b0;
                    s_d.sleep = 1'b0;
                end
            end
            PH_EXIT: begin
                s_d.cnt = cnt_inc;
                if (cnt_inc >= lim.exit_lim) begin
                    s_d.phase = PH_AWAKE;
                    s_d.cnt   = '0;
                    s_d.ready = 1'b1;
                end
            end
            default: s_d = SEQ_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= SEQ_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    assign sleep = s_q.sleep;
    assign ready = s_q.ready;
endmodule

// File: rtl/dsl_top.sv
module dsl_top
    import dsl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1ms,
    input  logic              port_idle,
    input  logic              sw_sleep_req,
    input  logic              wake_req,
    input  logic              cfg_we,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_rdata,
    output logic              sleep_o,
    output logic              link_ready_o
);
    cfg_t cfg;
    lim_t lim;

    dsl_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .rdata (cfg_rdata)
    );

    dsl_limits u_lim (
        .cfg (cfg),
        .lim (lim)
    );

    dsl_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_1ms),
        .port_idle (port_idle),
        .sw_req    (sw_sleep_req),
        .wake_req  (wake_req),
        .cfg       (cfg),
        .lim       (lim),
        .sleep     (sleep_o),
        .ready     (link_ready_o)
    );
endmodule

// File: rtl/dsl_chk.sv
module dsl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sw_req,
    input logic [31:0] cfg_word,
    input logic        sleep,
    input logic        ready
);
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_word[31:29] == 3'b000); // R2
    AST_READY_LOW_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !ready); // R8
    AST_ENTRY_NEEDS_PLATFORM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep) |-> $past(cfg_word[1])); // R5
    AST_IDLE_ENTRY_AGGR: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sleep) && !$past(sw_req)) |-> $past(cfg_word[0])); // R4
    AST_AGGR_CLEAR_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && $past(cfg_word[0]) && !cfg_word[0]) |=> !sleep); // R7
endmodule

bind dsl_top dsl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_req   (sw_sleep_req),
    .cfg_word (cfg_rdata),
    .sleep    (sleep_o),
    .ready    (link_ready_o)
);

// File: tb/dsl_top_test.sv
module dsl_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1ms = 1'b0;
    logic        port_idle = 1'b0;
    logic        sw_sleep_req = 1'b0;
    logic        wake_req = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        sleep_o;
    logic        link_ready_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dsl_top uut (.*);

    // Behavioural reference model
    logic [31:0] m_cfg;
    int  m_phase, m_cnt;
    bit  m_pend, m_aprev, m_sleep, m_ready;

    function automatic int floor1(int v);
        return (v == 0) ? 1 : v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = 32'h1E02_2852; m_phase = 0; m_cnt = 0;
            m_pend = 0; m_aprev = 0; m_sleep = 0; m_ready = 1;
        end else begin
            int  tk, ilim, hlim, elim;
            bit  ase, dsp;
            tk   = tick_1ms ? 1 : 0;
            ase  = m_cfg[0];
            dsp  = m_cfg[1];
            ilim = floor1(int'(m_cfg[24:15])) * (int'(m_cfg[28:25]) + 1);
            hlim = floor1(int'(m_cfg[14:10]));
            elim = floor1(int'(m_cfg[9:2]));
            if (m_phase == 0) begin
                m_cnt = port_idle ? m_cnt + tk : 0;
                if (m_cnt > 32767) m_cnt = 32767;
                if (dsp && (sw_sleep_req || (ase && port_idle && m_cnt >= ilim))) begin
                    m_phase = 1; m_cnt = 0; m_pend = 0; m_sleep = 1; m_ready = 0;
                end
            end else if (m_phase == 1) begin
                m_cnt = m_cnt + tk;
                m_pend = m_pend | wake_req;
                if (!dsp || (m_aprev && !ase) || (m_pend && m_cnt >= hlim)) begin
                    m_phase = 2; m_cnt = 0; m_pend = 0; m_sleep = 0;
                end
            end else begin
                m_cnt = m_cnt + tk;
                if (m_cnt >= elim) begin
                    m_phase = 0; m_cnt = 0; m_ready = 1;
                end
            end
            m_aprev = ase;
            if (cfg_we) m_cfg = cfg_wdata & 32'h1FFF_FFFF;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (sleep_o !== m_sleep) begin
                failures++;
                $display("FAIL R4 model sleep act=%b exp=%b", sleep_o, m_sleep);
            end
            checks++;
            if (link_ready_o !== m_ready) begin
                failures++;
                $display("FAIL R8 model ready act=%b exp=%b", link_ready_o, m_ready);
            end
            checks++;
            if (cfg_rdata !== m_cfg) begin
                failures++;
                $display("FAIL R1 model word act=%h exp=%h", cfg_rdata, m_cfg);
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            tick_1ms = 1'b1; step(); tick_1ms = 1'b0;
        end
    endtask

    task automatic wr(logic [31:0] w);
        cfg_wdata = w; cfg_we = 1'b1; step(); cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] word(int mult, int idle, int hold, int ex, bit dsp, bit ase);
        return (32'(mult) << 25) | (32'(idle) << 15) | (32'(hold) << 10)
             | (32'(ex) << 2) | (32'(dsp) << 1) | 32'(ase);
    endfunction

    task automatic pulse_sw();
        sw_sleep_req = 1'b1; step(); sw_sleep_req = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL R10 watchdog act=%0d exp=%0d", cycles, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step(); step();
        chk("R10 sleep in reset", 32'(sleep_o), 0);
        chk("R10 ready in reset", 32'(link_ready_o), 1);
        rst_n = 1'b1;
        step();
        chk("R1 reset word", cfg_rdata, 32'h1E02_2852);
        chk("R10 sleep after reset", 32'(sleep_o), 0);

        wr(32'hFFFF_FFFF);
        chk("R2 reserved bits", cfg_rdata, 32'h1FFF_FFFF);
        wr(word(0, 4, 10, 20, 1, 0));
        chk("R1 written word", cfg_rdata, word(0, 4, 10, 20, 1, 0));

        // R4: idle time alone never sleeps without aggressive entry
        port_idle = 1'b1;
        ticks(30);
        chk("R4 no idle entry", 32'(sleep_o), 0);
        pulse_sw();
        chk("R4 sw entry", 32'(sleep_o), 1);

        // R6: early wake waits for the hold
        wake_req = 1'b1; step(); wake_req = 1'b0;
        chk("R6 early wake held", 32'(sleep_o), 1);
        ticks(9);
        chk("R6 one tick short", 32'(sleep_o), 1);
        ticks(1);
        chk("R6 released on hold", 32'(sleep_o), 0);

        // R8: exit window, requests ignored
        chk("R8 ready low after exit", 32'(link_ready_o), 0);
        pulse_sw();
        chk("R8 request ignored in exit", 32'(sleep_o), 0);
        ticks(19);
        chk("R8 ready one tick short", 32'(link_ready_o), 0);
        ticks(1);
        chk("R8 ready rises", 32'(link_ready_o), 1);

        // R3: idle limit = 3 * (1+1) = 6, restart on idle drop
        port_idle = 1'b0;
        wr(word(1, 3, 10, 20, 1, 1));
        port_idle = 1'b1;
        ticks(5);
        port_idle = 1'b0; step(); port_idle = 1'b1;
        ticks(5);
        chk("R3 count restarted", 32'(sleep_o), 0);
        ticks(1);
        chk("R3 idle entry", 32'(sleep_o), 1);

        // R7: clearing aggressive forces exit before hold
        wr(word(1, 3, 10, 20, 1, 0));
        chk("R7 still asleep at write", 32'(sleep_o), 1);
        step();
        chk("R7 forced exit", 32'(sleep_o), 0);
        ticks(20);
        chk("R8 ready after forced exit", 32'(link_ready_o), 1);

        // R5: no platform support
        wr(word(0, 1, 10, 20, 0, 1));
        ticks(20);
        chk("R5 no idle entry w/o platform", 32'(sleep_o), 0);
        pulse_sw();
        chk("R5 no sw entry w/o platform", 32'(sleep_o), 0);
        wr(word(0, 1, 10, 20, 1, 0));
        pulse_sw();
        chk("R5 asleep with platform", 32'(sleep_o), 1);
        wr(word(0, 1, 10, 20, 0, 0));
        step();
        chk("R5 platform cleared wakes", 32'(sleep_o), 0);
        ticks(20);
        chk("R5 back to ready", 32'(link_ready_o), 1);

        // R9: zero fields act as one tick
        port_idle = 1'b0;
        wr(word(0, 0, 0, 0, 1, 1));
        port_idle = 1'b1;
        step();
        chk("R9 no entry without tick", 32'(sleep_o), 0);
        ticks(1);
        chk("R9 idle zero enters", 32'(sleep_o), 1);
        wake_req = 1'b1; step(); wake_req = 1'b0;
        chk("R9 hold zero needs a tick", 32'(sleep_o), 1);
        ticks(1);
        chk("R9 hold zero releases", 32'(sleep_o), 0);
        chk("R9 exit pending", 32'(link_ready_o), 0);
        ticks(1);
        chk("R9 exit zero ready", 32'(link_ready_o), 1);

        step();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule